// File: doc/BRIEF.md
# Three-Port Register-File RAM

This block is a small register-file memory of 64 words of 18 bits. It has one clocked write port and two read ports that run independently of each other. Typical uses are storing filter coefficients next to a multiply-accumulate datapath and serving as the storage for a small FIFO, where one side writes and two consumers read at their own addresses.

Each read port has its own timing mode, set by a static select pin. In asynchronous mode the port's data follows its address combinationally and ignores its enable. In synchronous mode the word is captured into an output register on the rising edge when the port enable is high, and is held while the enable is low. Reset clears the two output registers and leaves the stored words alone.

Top module: `rf3p_ram`

## Requirements
- R1: The array holds 64 separately addressable 18-bit words, addresses 0 to 63, and a read of any address returns the last word written there.
- R2: The two read ports work in the same cycle without interfering; when both are asynchronous and point at the same address, they show the same word.
- R3: A write takes place on the rising clock edge only when wr_en is 1; with wr_en at 0, the edge leaves the array unchanged.
- R4: A read port in synchronous mode (mode pin 1) keeps its output unchanged across an edge at which its enable is 0, even if its address changes.
- R5: A read port in synchronous mode with its enable at 1 presents, after the rising edge, the word stored at its address just before that edge; a read of the address being written at that edge returns the old word.
- R6: A read port in asynchronous mode (mode pin 0) shows the word at its current address without waiting for an edge, and shows the new word right after the edge that writes its address.
- R7: While rst_n is 0, both synchronous output registers read as 0; the stored words survive the reset.
- R8: In asynchronous mode the port enable has no effect: the output still follows the address with the enable at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write port and the read output registers |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 18 | Write data |
| rda_addr | input | 6 | Read port A address |
| rda_en | input | 1 | Read port A enable (synchronous mode only) |
| rda_sync | input | 1 | Read port A mode: 1 synchronous, 0 asynchronous |
| rdb_addr | input | 6 | Read port B address |
| rdb_en | input | 1 | Read port B enable (synchronous mode only) |
| rdb_sync | input | 1 | Read port B mode: 1 synchronous, 0 asynchronous |
| rda_data | output | 18 | Read port A data |
| rdb_data | output | 18 | Read port B data |

## Verification
The properties take the mode pins to be static in normal use: a hold or capture check only fires when the same port was synchronous at both edges, so a change of mode is outside what they claim. They also assume reset release is already aligned to the clock and that a word is written before it is read, since the array has no reset value. The stimulus changes mode pins only on the falling edge between tests, releases reset on a falling edge, and fills all 64 words before any read is checked.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;
  localparam int unsigned RF_DEPTH = 64;
  localparam int unsigned RF_WIDTH = 18;
  localparam int unsigned RF_NRD   = 2;

  typedef enum logic {
    RD_ASYNC = 1'b0,
    RD_SYNC  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rf3p_array.sv
module rf3p_array #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 18,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rword
);
  logic [WIDTH-1:0] mem [DEPTH];

  // storage: no reset, contents survive rst_n
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    always_comb rword[p] = mem[raddr[p]];
  end

  // R3: an enabled edge leaves the presented word in the addressed slot
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rf3p_rdport.sv
module rf3p_rdport
  import rf3p_pkg::*;
#(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;
  logic             is_sync;

  assign is_sync = (rd_mode_e'(mode) == RD_SYNC);

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

  assign dout = is_sync ? q : word;

  // R4: an idle synchronous port keeps its output
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sync && !en) |=> (!is_sync || $stable(dout)));

  // R5: an enabled synchronous port shows the word seen before the edge
  p_sync_old_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sync && en) |=> (!is_sync || dout == $past(word)));
endmodule

// File: rtl/rf3p_ram.sv
module rf3p_ram
  import rf3p_pkg::*;
#(
  parameter int unsigned DEPTH = RF_DEPTH,
  parameter int unsigned WIDTH = RF_WIDTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rda_addr,
  input  logic             rda_en,
  input  logic             rda_sync,
  input  logic [AW-1:0]    rdb_addr,
  input  logic             rdb_en,
  input  logic             rdb_sync,
  output logic [WIDTH-1:0] rda_data,
  output logic [WIDTH-1:0] rdb_data
);
  localparam int unsigned NRD = RF_NRD;

  logic [NRD-1:0][AW-1:0]    raddr;
  logic [NRD-1:0][WIDTH-1:0] rword;
  logic [NRD-1:0][WIDTH-1:0] rdata;
  logic [NRD-1:0]            ren;
  logic [NRD-1:0]            rmode;

  assign raddr = {rdb_addr, rda_addr};
  assign ren   = {rdb_en, rda_en};
  assign rmode = {rdb_sync, rda_sync};

  rf3p_array #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .NRD   (NRD)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (raddr),
    .rword (rword)
  );

  for (genvar p = 0; p < int'(NRD); p++) begin : g_port
    rf3p_rdport #(
      .WIDTH (WIDTH)
    ) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ren[p]),
      .mode  (rmode[p]),
      .word  (rword[p]),
      .dout  (rdata[p])
    );
  end

  assign rda_data = rdata[0];
  assign rdb_data = rdata[1];

  // R2: two asynchronous ports on one address agree
  p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rda_sync && !rdb_sync && rda_addr == rdb_addr) |-> rda_data == rdb_data);

  // R6: an asynchronous port sees a write at its address right after the edge
  p_async_sees_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rda_sync) |=>
      (rda_sync || rda_addr != $past(wr_addr) || rda_data == $past(wr_data)));
endmodule

// File: tb/sim_rf3p_ram.sv
`timescale 1ns/1ps
module sim_rf3p_ram;
  localparam int AW = 6;
  localparam int W  = 18;
  localparam int N  = 64;

  // {a_sync, a_addr, b_sync, b_addr}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 6'd0,  1'b1, 6'd63},
    {1'b0, 6'd1,  1'b0, 6'd1},
    {1'b1, 6'd17, 1'b0, 6'd42},
    {1'b0, 6'd63, 1'b1, 6'd0},
    {1'b1, 6'd31, 1'b1, 6'd31},
    {1'b0, 6'd32, 1'b0, 6'd5},
    {1'b1, 6'd21, 1'b0, 6'd21},
    {1'b0, 6'd10, 1'b1, 6'd54}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;
  logic [AW-1:0] rda_addr, rdb_addr;
  logic          rda_en, rdb_en, rda_sync, rdb_sync;
  logic [W-1:0]  rda_data, rdb_data;

  logic [W-1:0]  model [N];
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  rf3p_ram u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rda_addr(rda_addr), .rda_en(rda_en), .rda_sync(rda_sync),
    .rdb_addr(rdb_addr), .rdb_en(rdb_en), .rdb_sync(rdb_sync),
    .rda_data(rda_data), .rdb_data(rdb_data)
  );

  function automatic logic [W-1:0] pat(int i);
    return W'(i * 997 + 5);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rda_addr = '0; rdb_addr = '0; rda_en = 1'b0; rdb_en = 1'b0;
    rda_sync = 1'b1; rdb_sync = 1'b1;
    tick(); tick();
    // R7: output registers cleared by reset
    chk("R7 reset port A", rda_data, '0);
    chk("R7 reset port B", rdb_data, '0);
    rst_n = 1'b1;

    // R1 R3: fill every word
    for (int i = 0; i < N; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
      tick();
      model[i] = pat(i);
    end
    wr_en = 1'b0;

    // R1 R2 R5 R6: table walk, both ports enabled
    rda_en = 1'b1; rdb_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      {rda_sync, rda_addr, rdb_sync, rdb_addr} = VEC[v];
      tick();
      chk("R1/R5/R6 table port A", rda_data, model[rda_addr]);
      chk("R2/R5/R6 table port B", rdb_data, model[rdb_addr]);
    end

    // R4: synchronous hold with enable low
    rda_sync = 1'b1; rda_addr = 6'd7; rda_en = 1'b1;
    tick();
    rda_en = 1'b0; rda_addr = 6'd8;
    tick();
    chk("R4 hold port A", rda_data, model[7]);
    rdb_sync = 1'b1; rdb_addr = 6'd9; rdb_en = 1'b1;
    tick();
    rdb_en = 1'b0; rdb_addr = 6'd60;
    tick();
    chk("R4 hold port B", rdb_data, model[9]);

    // R5 R6: read during write at address 12
    rda_sync = 1'b1; rda_en = 1'b1; rda_addr = 6'd12;
    rdb_sync = 1'b0; rdb_en = 1'b1; rdb_addr = 6'd12;
    wr_en = 1'b1; wr_addr = 6'd12; wr_data = 18'h2A5C3;
    #1;
    chk("R6 async before write edge", rdb_data, model[12]);
    tick();
    chk("R5 sync returns old word", rda_data, model[12]);
    chk("R6 async shows new word", rdb_data, 18'h2A5C3);
    model[12] = 18'h2A5C3;
    wr_en = 1'b0;
    tick();
    chk("R5 sync next read new word", rda_data, model[12]);

    // R3: write disabled leaves word unchanged
    wr_en = 1'b0; wr_addr = 6'd40; wr_data = 18'h3FFFF;
    rdb_sync = 1'b0; rdb_addr = 6'd40;
    tick();
    chk("R3 no write when disabled", rdb_data, model[40]);

    // R8: async port ignores enable
    rdb_en = 1'b0; rdb_addr = 6'd33;
    #1;
    chk("R8 async with enable low", rdb_data, model[33]);
    rdb_addr = 6'd34;
    #1;
    chk("R8 async follows address", rdb_data, model[34]);

    // R7: mid-run reset clears registers, keeps array
    rda_sync = 1'b1; rda_en = 1'b1; rda_addr = 6'd50;
    rdb_sync = 1'b1; rdb_en = 1'b1; rdb_addr = 6'd51;
    tick();
    rst_n = 1'b0;
    #1;
    chk("R7 async clear port A", rda_data, '0);
    chk("R7 async clear port B", rdb_data, '0);
    tick();
    rst_n = 1'b1;
    rda_sync = 1'b0; rdb_sync = 1'b0;
    #1;
    chk("R7 array kept A", rda_data, model[50]);
    chk("R7 array kept B", rdb_data, model[51]);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule